// File: doc/BRIEF.md
# Segmented programmable divide-by-N counter

This block divides its clock by a programmable ratio N. It emits one output pulse, one clock wide, every N clock cycles. The counter counts down and has three segments chained by borrows. The low segment is a fast counter whose modulus (2, 4, 5, 8 or 10) comes from a three-bit mode select. Above it sit three cascaded BCD decades. Above those is a small most-significant segment built from the low-nibble flip-flops that the chosen modulus leaves unused.

A 16-bit preset word sets N. Its low nibble is split between the fast segment (low bits) and the top segment (remaining high bits). The next three nibbles are the decades: units, tens and hundreds. The ratio is N = (top × 1000 + decades) × modulus + fast. In the divide-by-2 mode this reaches 15,999, and in the divide-by-10 mode N reads directly as a four-digit BCD number. When the count reaches its terminal state, every segment reloads from the preset and mode inputs on the next clock edge. The preset and mode are therefore only sampled at reload or reset.

Top module: `seg_divn`

## Requirements
- R1: With preset value N ≥ 2, pulse_o is high for exactly one cycle out of every N. The first pulse comes in the cycle after the (N−1)th clock edge that follows the reset edge.
- R2: A pulse lasts one clock cycle when N ≥ 2, including N = 2 and N = 3.
- R3: Mode codes sel_i = 000/001/010/011/100 select fast moduli 2/4/5/10/8. The fast segment takes the low 1/2/3/4/3 bits of preset_i[3:0], and the remaining high bits of that nibble form the top segment (weight 1000 × modulus).
- R4: preset_i[7:4], [11:8] and [15:12] are the units, tens and hundreds BCD digits of the middle segment.
- R5: A BCD preset digit above 9 counts as 9.
- R6: A fast-segment preset at or above the modulus counts as modulus − 1.
- R7: In mode 000 with preset 0x999F, the ratio is 15,999.
- R8: A loaded value of 0 or 1 makes pulse_o stay high in every cycle after the first cycle following reset.
- R9: rst_i is synchronous and active high. It forces pulse_o low while asserted and in the cycle after its edge, and it restarts the count from the preset.
- R10: Changes to preset_i or sel_i during a count take effect only at the next reload.
- R11: The unassigned mode codes 101, 110 and 111 behave as divide-by-10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset and reload |
| sel_i | input | 3 | Fast-segment modulus select |
| preset_i | input | 16 | Division ratio preset word |
| pulse_o | output | 1 | One-cycle output pulse, period N |

## Verification
The bench counts clock edges from the reset edge. With loaded value N, the first pulse is due after edge N−1 and the next after edge 2N−1, and the line must be low everywhere else. Each vector is run for 2N edges, and the edge index of every high sample is recorded at the falling edge, so an off-by-one period shows up as a wrong index. A preset or mode change made after edge 1 is due to act only on the period that starts after the first pulse. The directed tests therefore expect the second pulse at the first pulse index plus the new N. The reset checks sample the output in the cycle that the reset edge opens.

// File: rtl/seg_divn_pkg.sv
package seg_divn_pkg;

    localparam int NIB_W   = 4;
    localparam int TOP_W   = 3;
    localparam int DIG_MAX = 9;

    typedef enum logic [2:0] {
        SEL_DIV2  = 3'b000,
        SEL_DIV4  = 3'b001,
        SEL_DIV5  = 3'b010,
        SEL_DIV10 = 3'b011,
        SEL_DIV8  = 3'b100
    } fsel_e;

    typedef struct packed {
        logic [NIB_W-1:0] mod_m1;   // fast modulus minus one
        logic [2:0]       fbits;    // nibble bits owned by fast segment
        logic [TOP_W-1:0] top_max;  // largest top-segment value
    } seg_cfg_t;

    function automatic seg_cfg_t decode_sel(input logic [2:0] sel);
        seg_cfg_t c;
        case (sel)
            SEL_DIV2:  c = '{mod_m1: 4'd1, fbits: 3'd1, top_max: 3'd7};
            SEL_DIV4:  c = '{mod_m1: 4'd3, fbits: 3'd2, top_max: 3'd3};
            SEL_DIV5:  c = '{mod_m1: 4'd4, fbits: 3'd3, top_max: 3'd1};
            SEL_DIV8:  c = '{mod_m1: 4'd7, fbits: 3'd3, top_max: 3'd1};
            default:   c = '{mod_m1: 4'd9, fbits: 3'd4, top_max: 3'd0};
        endcase
        return c;
    endfunction

    function automatic logic [NIB_W-1:0] bcd_sat(input logic [NIB_W-1:0] d);
        return (d > NIB_W'(DIG_MAX)) ? NIB_W'(DIG_MAX) : d;
    endfunction

    function automatic logic [NIB_W-1:0] fast_load(input logic [NIB_W-1:0] nib,
                                                   input seg_cfg_t c);
        logic [NIB_W:0]   wide;
        logic [NIB_W-1:0] v;
        wide = ((NIB_W+1)'(1) << c.fbits) - (NIB_W+1)'(1);
        v    = nib & wide[NIB_W-1:0];
        return (v > c.mod_m1) ? c.mod_m1 : v;
    endfunction

    function automatic logic [TOP_W-1:0] top_load(input logic [NIB_W-1:0] nib,
                                                  input seg_cfg_t c);
        logic [NIB_W-1:0] sh;
        sh = nib >> c.fbits;
        return sh[TOP_W-1:0];
    endfunction

endpackage

// File: rtl/seg_divn_fast.sv
module seg_divn_fast
    import seg_divn_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [NIB_W-1:0] load_val_i,
    input  logic [NIB_W-1:0] mod_m1_i,
    output logic [NIB_W-1:0] val_o,
    output logic             borrow_o
);

    logic [NIB_W-1:0] val_q;

    always_ff @(posedge clk_i) begin
        if (load_i)
            val_q <= load_val_i;
        else if (val_q == '0)
            val_q <= mod_m1_i;
        else
            val_q <= val_q - NIB_W'(1);
    end

    assign val_o    = val_q;
    assign borrow_o = (val_q == '0) && !load_i;

    // R6: the fast value never leaves the range of the active modulus
    p_fast_range_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        val_q <= mod_m1_i);

    // R1: underflow wraps to modulus minus one
    p_fast_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && val_q == '0) |=> (val_q == $past(mod_m1_i)));

endmodule

// File: rtl/seg_divn_decade.sv
module seg_divn_decade
    import seg_divn_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [NIB_W-1:0] load_digit_i,
    input  logic             dec_i,
    output logic             zero_o,
    output logic             borrow_o
);

    logic [NIB_W-1:0] digit_q;

    always_ff @(posedge clk_i) begin
        if (load_i)
            digit_q <= load_digit_i;
        else if (dec_i)
            digit_q <= (digit_q == '0) ? NIB_W'(DIG_MAX) : digit_q - NIB_W'(1);
    end

    assign zero_o   = (digit_q == '0);
    assign borrow_o = dec_i && zero_o && !load_i;

    // R5: every decade holds a legal BCD digit
    p_digit_bcd_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        digit_q <= NIB_W'(DIG_MAX));

    // R4: a decade wraps from zero to nine when borrowed from
    p_decade_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_i && zero_o && !load_i) |=> (digit_q == NIB_W'(DIG_MAX)));

endmodule

// File: rtl/seg_divn_top_seg.sv
module seg_divn_top_seg
    import seg_divn_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [TOP_W-1:0] load_val_i,
    input  logic [TOP_W-1:0] max_i,
    input  logic             dec_i,
    output logic             zero_o
);

    logic [TOP_W-1:0] val_q;

    always_ff @(posedge clk_i) begin
        if (load_i)
            val_q <= load_val_i;
        else if (dec_i)
            val_q <= (val_q == '0) ? max_i : val_q - TOP_W'(1);
    end

    assign zero_o = (val_q == '0);

    // R3: the top segment stays within the bits the mode leaves free
    p_top_limit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        val_q <= max_i);

endmodule

// File: rtl/seg_divn.sv
module seg_divn
    import seg_divn_pkg::*;
#(
    parameter  int DECADES  = 3,
    localparam int PRESET_W = NIB_W * (DECADES + 1)
)(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [2:0]          sel_i,
    input  logic [PRESET_W-1:0] preset_i,
    output logic                pulse_o
);

    seg_cfg_t          cfg_ld;
    logic [NIB_W-1:0]  mod_m1_q;
    logic [TOP_W-1:0]  top_max_q;
    logic              fresh_q;
    logic              load;
    logic              term;
    logic              ld_small;

    logic [NIB_W-1:0]  fast_v;
    logic [NIB_W-1:0]  fast_ld;
    logic [TOP_W-1:0]  top_ld;
    logic              top_zero;
    logic [DECADES:0]  dec_chain;
    logic [DECADES-1:0] dig_zero;
    logic [DECADES-1:0] dig_ld_zero;

    assign cfg_ld  = decode_sel(sel_i);
    assign fast_ld = fast_load(preset_i[NIB_W-1:0], cfg_ld);
    assign top_ld  = top_load(preset_i[NIB_W-1:0], cfg_ld);

    // Mode is captured only at reload so a mid-count change cannot corrupt it.
    always_ff @(posedge clk_i) begin
        if (load) begin
            mod_m1_q  <= cfg_ld.mod_m1;
            top_max_q <= cfg_ld.top_max;
        end
        fresh_q <= rst_i;
    end

    seg_divn_fast u_fast (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .load_val_i (fast_ld),
        .mod_m1_i   (mod_m1_q),
        .val_o      (fast_v),
        .borrow_o   (dec_chain[0])
    );

    for (genvar k = 0; k < DECADES; k++) begin : g_dec
        logic [NIB_W-1:0] dig_ld;
        assign dig_ld         = bcd_sat(preset_i[NIB_W*(k+1) +: NIB_W]);
        assign dig_ld_zero[k] = (dig_ld == '0);

        seg_divn_decade u_decade (
            .clk_i        (clk_i),
            .rst_i        (rst_i),
            .load_i       (load),
            .load_digit_i (dig_ld),
            .dec_i        (dec_chain[k]),
            .zero_o       (dig_zero[k]),
            .borrow_o     (dec_chain[k+1])
        );
    end

    seg_divn_top_seg u_top (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .load_val_i (top_ld),
        .max_i      (top_max_q),
        .dec_i      (dec_chain[DECADES]),
        .zero_o     (top_zero)
    );

    // Terminal state: whole mixed-radix value is one (or a preset zero).
    assign term     = (fast_v <= NIB_W'(1)) && (&dig_zero) && top_zero;
    assign load     = rst_i || term;
    assign pulse_o  = term && !fresh_q && !rst_i;

    // Value about to be loaded is 0 or 1.
    assign ld_small = (fast_ld <= NIB_W'(1)) && (&dig_ld_zero) && (top_ld == '0);

    // R9: the cycle opened by a reset edge is quiet
    p_quiet_after_reset_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !pulse_o);

    // R2: a pulse is followed by a low cycle unless the reload value is tiny
    p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (pulse_o && !ld_small) |=> !pulse_o);

    // R10: mode state changes only at reload
    p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !load |=> ($stable(mod_m1_q) && $stable(top_max_q)));

endmodule

// File: tb/seg_divn_tb_top.sv
module seg_divn_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] preset;
        logic [15:0] n;
        logic [3:0]  req;
    } vec_t;

    // Expected ratios worked out by hand from the requirements.
    localparam vec_t VECS [NVEC] = '{
        '{3'b011, 16'h0037, 16'd37,    4'd1},   // R1 divide-by-10, BCD 37
        '{3'b011, 16'h0123, 16'd123,   4'd4},   // R4 tens and units digits
        '{3'b000, 16'h0055, 16'd4011,  4'd3},   // R3 /2: fast 1, top 2, mid 5
        '{3'b001, 16'h0026, 16'd4010,  4'd3},   // R3 /4: fast 2, top 1, mid 2
        '{3'b010, 16'h0013, 16'd8,     4'd3},   // R3 /5: fast 3, mid 1
        '{3'b010, 16'h0017, 16'd9,     4'd6},   // R6 fast 7 clamps to 4
        '{3'b100, 16'h002F, 16'd8023,  4'd3},   // R3 /8: fast 7, top 1, mid 2
        '{3'b011, 16'h00A3, 16'd93,    4'd5},   // R5 units digit 10 -> 9
        '{3'b011, 16'h000C, 16'd9,     4'd6},   // R6 fast 12 clamps to 9
        '{3'b111, 16'h0037, 16'd37,    4'd11},  // R11 code 111 acts as /10
        '{3'b101, 16'h0004, 16'd4,     4'd11},  // R11 code 101 acts as /10
        '{3'b000, 16'h999F, 16'd15999, 4'd7},   // R7 largest ratio
        '{3'b011, 16'h0003, 16'd3,     4'd1},   // R1 smallest documented N
        '{3'b011, 16'h0002, 16'd2,     4'd2},   // R2 back-to-back periods
        '{3'b011, 16'hF001, 16'd9001,  4'd5}    // R5 hundreds digit 15 -> 9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'b011;
    logic [15:0] preset = 16'h0005;
    logic        pulse;

    int checks   = 0;
    int failures = 0;

    seg_divn dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .sel_i    (sel),
        .preset_i (preset),
        .pulse_o  (pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply reset with the given settings; returns at the falling edge
    // just after the reset edge (edge index 0), with reset released.
    task automatic do_reset(input logic [2:0] s, input logic [15:0] p);
        @(negedge clk);
        sel    = s;
        preset = p;
        rst    = 1'b1;
        #1;
        check(pulse == 1'b0, "R9", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b0, "R9", int'(pulse), 0);
        rst = 1'b0;
    endtask

    // Sample pulse after edges a..b; report first two high indices and count.
    task automatic observe(input int a, input int b,
                           output int h1, output int h2, output int cnt);
        h1 = -1; h2 = -1; cnt = 0;
        for (int c = a; c <= b; c++) begin
            @(negedge clk);
            if (pulse) begin
                if (cnt == 0) h1 = c;
                else if (cnt == 1) h2 = c;
                cnt++;
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int h1, h2, cnt;
        string tag;

        // Reset state (R9)
        do_reset(3'b011, 16'h0005);

        // Table walk: R1, R2, R3, R4, R5, R6, R7, R11
        for (int i = 0; i < NVEC; i++) begin
            int n;
            n   = int'(VECS[i].n);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            do_reset(VECS[i].sel, VECS[i].preset);
            observe(1, 2*n, h1, h2, cnt);
            check(h1 == n - 1,     tag, h1, n - 1);
            check(h2 == 2*n - 1,   tag, h2, 2*n - 1);
            check(cnt == 2,        tag, cnt, 2);
        end

        // R8: loaded value 1, then 0, pulse stays high
        do_reset(3'b011, 16'h0001);
        observe(1, 6, h1, h2, cnt);
        check(cnt == 6, "R8 preset 1", cnt, 6);
        do_reset(3'b011, 16'h0000);
        observe(1, 6, h1, h2, cnt);
        check(cnt == 6, "R8 preset 0", cnt, 6);

        // R10: preset change mid-count waits for the reload
        do_reset(3'b011, 16'h0005);
        @(negedge clk);
        preset = 16'h0007;
        observe(2, 12, h1, h2, cnt);
        check(h1 == 4,  "R10 preset", h1, 4);
        check(h2 == 11, "R10 preset", h2, 11);

        // R10: mode change mid-count waits for the reload (/2 -> 2001)
        do_reset(3'b011, 16'h0003);
        @(negedge clk);
        sel = 3'b000;
        observe(2, 2004, h1, h2, cnt);
        check(h1 == 2,    "R10 mode", h1, 2);
        check(h2 == 2003, "R10 mode", h2, 2003);
        check(cnt == 2,   "R10 mode", cnt, 2);

        // R9: reset in mid-count restarts the period
        do_reset(3'b011, 16'h0037);
        observe(1, 10, h1, h2, cnt);
        check(cnt == 0, "R9 before mid reset", cnt, 0);
        rst = 1'b1;
        #1;
        check(pulse == 1'b0, "R9 held", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b0, "R9 after edge", int'(pulse), 0);
        rst = 1'b0;
        observe(1, 40, h1, h2, cnt);
        check(h1 == 36, "R9 restart", h1, 36);
        check(cnt == 1, "R9 restart", cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule